// File: doc/BRIEF.md
# PCI Power-Management Capability Slave

This block is the configuration-space responder for one PCI function that advertises power management. It answers dword-indexed configuration reads and byte-enabled writes. It reports a capabilities list through a flag in the status half of dword 1. A pointer byte in dword 5 names where the power-management item starts. The item itself is two dwords: an identifier and link dword carrying the static capability word, then a control/status dword that selects the device power state and handles the wake event.

The selected state is driven on `pstate_o`. Outside the fully-on state D0, the memory and I/O decode enables are forced low, while configuration traffic keeps working. A wake request on `pme_event_i` latches a status bit. That bit raises `wake_o` only while software has enabled it, and software clears it by writing a one.

Configuration requests use valid/ready. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. A write takes effect on that edge and gives no response. A read captures its data on that edge and presents it on `rsp_valid_o`/`rsp_rdata_o`, holding it stable until a clock edge where `rsp_ready_i` is high. While a read response is waiting, `req_ready_o` is low, so at most one read is outstanding.

Top module: `pmcap_top`

## Requirements
- R1: After reset the state is D0, the command enables, wake enable and wake status are 0, `wake_o` is low, `req_ready_o` is high and no response is pending.
- R2: Dword 1 reads with bit 20 (status bit 4) set to 1 and status otherwise 0. Dword 5 reads the pointer byte `CAP_PTR` (default 40h) in bits 7:0 and zero above. Dword 0 reads the parameter `ID_WORD`.
- R3: The item dword at index `CAP_PTR/4` reads ID 01h in bits 7:0, next pointer 00h in bits 15:8 and the parameter `PMC` (default 0A03h) in bits 31:16.
- R4: Writes to dword 0, to the item dword holding `PMC`, and to any unused index leave every read value unchanged.
- R5: The control dword at index `CAP_PTR/4+1` holds the state in bits 1:0 (00 D0, 01 D1, 10 D2, 11 D3), written when byte enable 0 is set. D0 and D3 are always accepted. D1 is accepted only if `PMC` bit 9 is set, and D2 only if `PMC` bit 10 is set. Any other request leaves the state unchanged. `pstate_o` shows the state.
- R6: Control bit 15 (wake status) is set by `pme_event_i`. A write of 1 to it with byte enable 1 clears it, and a write of 0 does not. When the event and the clear fall in the same cycle, the event wins.
- R7: Control bit 8 (wake enable) is written with byte enable 1. `wake_o` is high exactly when wake status and wake enable are both 1.
- R8: Dword 1 bits 0 (I/O) and 1 (memory) are written with byte enable 0. `io_en_o`/`mem_en_o` follow them only in D0 and are low in D1 to D3. Configuration reads and writes are still served in D1 to D3.
- R9: Control bits 31:24 read the measurement byte `DATA_TBL[8*state +: 8]` for the current state (defaults D0 28h, D1 14h, D2 0Ah, D3 05h).
- R10: A read response appears on the edge after acceptance and holds `rsp_rdata_o` stable while `rsp_ready_i` is low. `req_ready_o` is low while a response is pending. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Configuration request valid |
| req_ready_o | output | 1 | Request can be taken |
| req_write_i | input | 1 | 1 write, 0 read |
| req_index_i | input | IDX_W | Dword index in configuration space |
| req_be_i | input | 4 | Byte enables for writes |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_ready_i | input | 1 | Consumer takes read data |
| rsp_rdata_o | output | 32 | Read data |
| pstate_o | output | 2 | Current device power state |
| io_en_o | output | 1 | Effective I/O decode enable |
| mem_en_o | output | 1 | Effective memory decode enable |
| pme_event_i | input | 1 | Wake request from the function |
| wake_o | output | 1 | Wake event output |

## Verification
The register map is first read in its reset state. Then all-ones patterns are written to the read-only and unused dwords to show they stick at their fixed values. State writes go through every encoding, including the unsupported D2 request and a write with the low byte disabled. This separates correct gating by capability bits and byte enables from a blind field update, and the decode-enable outputs and measurement byte are compared in each state. The wake path is driven with the event alone, with enable written with zero status, with a write-one clear, and with event and clear in one cycle. These cases tell set priority and enable masking apart. Reads run under a toggling response-ready pattern and under a held stall, which shows the single-outstanding rule and data holding.

// File: rtl/pmcap_pkg.sv
package pmcap_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  localparam int unsigned ST_LSB      = 0;
  localparam int unsigned WEN_BIT     = 8;
  localparam int unsigned WSTS_BIT    = 15;
  localparam int unsigned PMC_D1_BIT  = 9;
  localparam int unsigned PMC_D2_BIT  = 10;
  localparam logic [7:0]  PM_CAP_ID   = 8'h01;
  localparam logic [15:0] STATUS_WORD = 16'h0010;
endpackage

// File: rtl/pmcap_cfgport.sv
module pmcap_cfgport (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [31:0] rd_data_i,
  input  logic        rsp_ready_i,
  output logic        req_ready_o,
  output logic        accept_o,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o
);
  assign req_ready_o = !rsp_valid_o;
  assign accept_o    = req_valid_i && req_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else if (accept_o && !req_write_i) begin
      rsp_valid_o <= 1'b1;
      rsp_rdata_o <= rd_data_i;
    end else if (rsp_valid_o && rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pmcap_pwrstate.sv
module pmcap_pwrstate
  import pmcap_pkg::*;
#(
  parameter logic [15:0] PMC = 16'h0A03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  input  logic        pme_event_i,
  output pstate_e     state_o,
  output logic        pme_en_o,
  output logic        pme_sts_o
);
  logic [1:0] req_st;
  logic       st_ok;

  assign req_st = wdata_i[ST_LSB +: 2];

  always_comb begin
    unique case (req_st)
      2'b01:   st_ok = PMC[PMC_D1_BIT];
      2'b10:   st_ok = PMC[PMC_D2_BIT];
      default: st_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_o   <= PS_D0;
      pme_en_o  <= 1'b0;
      pme_sts_o <= 1'b0;
    end else begin
      if (wr_i && be_i[0] && st_ok) state_o <= pstate_e'(req_st);
      if (wr_i && be_i[1]) pme_en_o <= wdata_i[WEN_BIT];
      if (pme_event_i) pme_sts_o <= 1'b1;
      else if (wr_i && be_i[1] && wdata_i[WSTS_BIT]) pme_sts_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pmcap_rdmux.sv
module pmcap_rdmux
  import pmcap_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter logic [31:0] ID_WORD  = 32'h5A31_1F2C,
  parameter logic [7:0]  CAP_PTR  = 8'h40,
  parameter logic [15:0] PMC      = 16'h0A03,
  parameter logic [31:0] DATA_TBL = 32'h050A_1428
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cmd_io_i,
  input  logic             cmd_mem_i,
  input  pstate_e          state_i,
  input  logic             pme_en_i,
  input  logic             pme_sts_i,
  output logic [31:0]      rdata_o
);
  localparam logic [IDX_W-1:0] CAP_IDX = IDX_W'(CAP_PTR >> 2);
  localparam logic [IDX_W-1:0] CSR_IDX = CAP_IDX + IDX_W'(1);
  localparam logic [IDX_W-1:0] CMD_IDX = IDX_W'(1);
  localparam logic [IDX_W-1:0] PTR_IDX = IDX_W'(5);

  logic [7:0]  meas;
  logic [31:0] csr_word;

  assign meas = DATA_TBL[{state_i, 3'b000} +: 8];

  always_comb begin
    csr_word = '0;
    csr_word[31:24]          = meas;
    csr_word[WSTS_BIT]       = pme_sts_i;
    csr_word[WEN_BIT]        = pme_en_i;
    csr_word[ST_LSB +: 2]    = state_i;
  end

  always_comb begin
    if (idx_i == '0)            rdata_o = ID_WORD;
    else if (idx_i == CMD_IDX)  rdata_o = {STATUS_WORD, 14'b0, cmd_mem_i, cmd_io_i};
    else if (idx_i == PTR_IDX)  rdata_o = {24'b0, CAP_PTR};
    else if (idx_i == CAP_IDX)  rdata_o = {PMC, 8'h00, PM_CAP_ID};
    else if (idx_i == CSR_IDX)  rdata_o = csr_word;
    else                        rdata_o = '0;
  end
endmodule

// File: rtl/pmcap_top.sv
module pmcap_top
  import pmcap_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter logic [31:0] ID_WORD  = 32'h5A31_1F2C,
  parameter logic [7:0]  CAP_PTR  = 8'h40,
  parameter logic [15:0] PMC      = 16'h0A03,
  parameter logic [31:0] DATA_TBL = 32'h050A_1428
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [IDX_W-1:0] req_index_i,
  input  logic [3:0]       req_be_i,
  input  logic [31:0]      req_wdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [31:0]      rsp_rdata_o,
  output logic [1:0]       pstate_o,
  output logic             io_en_o,
  output logic             mem_en_o,
  input  logic             pme_event_i,
  output logic             wake_o
);
  localparam logic [IDX_W-1:0] CSR_IDX = IDX_W'(CAP_PTR >> 2) + IDX_W'(1);
  localparam logic [IDX_W-1:0] CMD_IDX = IDX_W'(1);

  logic        accept;
  logic        wr_fire;
  logic [31:0] rd_data;
  logic        cmd_io, cmd_mem;
  pstate_e     state;
  logic        pme_en, pme_sts;

  pmcap_cfgport u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .rd_data_i(rd_data), .rsp_ready_i(rsp_ready_i),
    .req_ready_o(req_ready_o), .accept_o(accept),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
  );

  assign wr_fire = accept && req_write_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_io  <= 1'b0;
      cmd_mem <= 1'b0;
    end else if (wr_fire && req_index_i == CMD_IDX && req_be_i[0]) begin
      cmd_io  <= req_wdata_i[0];
      cmd_mem <= req_wdata_i[1];
    end
  end

  pmcap_pwrstate #(.PMC(PMC)) u_pwr (
    .clk(clk), .rst_n(rst_n),
    .wr_i(wr_fire && req_index_i == CSR_IDX),
    .be_i(req_be_i), .wdata_i(req_wdata_i),
    .pme_event_i(pme_event_i),
    .state_o(state), .pme_en_o(pme_en), .pme_sts_o(pme_sts)
  );

  pmcap_rdmux #(
    .IDX_W(IDX_W), .ID_WORD(ID_WORD), .CAP_PTR(CAP_PTR),
    .PMC(PMC), .DATA_TBL(DATA_TBL)
  ) u_rd (
    .idx_i(req_index_i), .cmd_io_i(cmd_io), .cmd_mem_i(cmd_mem),
    .state_i(state), .pme_en_i(pme_en), .pme_sts_i(pme_sts),
    .rdata_o(rd_data)
  );

  assign pstate_o = state;
  assign io_en_o  = cmd_io  && (state == PS_D0);
  assign mem_en_o = cmd_mem && (state == PS_D0);
  assign wake_o   = pme_sts && pme_en;
endmodule

// File: rtl/pmcap_chk.sv
module pmcap_chk #(
  parameter logic [15:0] PMC = 16'h0A03
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [31:0] rsp_rdata_o,
  input logic [1:0]  pstate_o,
  input logic        io_en_o,
  input logic        mem_en_o,
  input logic        wake_o,
  input logic        pme_event_i,
  input logic        pme_en,
  input logic        pme_sts
);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o);

  // R8
  decode_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_o != 2'b00) |-> (!io_en_o && !mem_en_o));

  // R5
  d2_unsupported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_o != 2'b10) || PMC[10]);

  // R6
  wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pme_event_i |=> pme_sts);

  // R7
  wake_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> pme_en);
endmodule

bind pmcap_top pmcap_chk #(.PMC(PMC)) i_chk (.*);

// File: tb/test_pmcap_top.sv
module test_pmcap_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [5:0]  req_index_i = '0;
  logic [3:0]  req_be_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [31:0] rsp_rdata_o;
  logic [1:0]  pstate_o;
  logic        io_en_o, mem_en_o;
  logic        pme_event_i = 1'b0;
  logic        wake_o;

  int n_chk = 0;
  int n_fail = 0;
  logic hold_rsp = 1'b0;
  logic [2:0] rdy_cnt = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmcap_top i_pmcap_top (.*);

  always @(posedge clk) begin
    rdy_cnt     <= rdy_cnt + 3'd1;
    rsp_ready_i <= !hold_rsp && (rdy_cnt[1:0] != 2'b01);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid_o && rsp_ready_i) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata_o);
      end else begin
        check(tag_q.pop_front(), rsp_rdata_o, exp_q.pop_front());
      end
    end
  end

  task automatic issue(input logic wr, input logic [5:0] idx, input logic [3:0] be,
                       input logic [31:0] wd);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_index_i = idx;
    req_be_i = be; req_wdata_i = wd;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic cfg_wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] wd);
    issue(1'b1, idx, be, wd);
  endtask

  task automatic cfg_rd(input logic [5:0] idx, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(1'b0, idx, 4'h0, 32'h0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pstate", 32'(pstate_o), 32'h0);
    check("R1 io/mem", {30'b0, io_en_o, mem_en_o}, 32'h0);
    check("R1 wake", 32'(wake_o), 32'h0);
    check("R1 ready/rsp", {30'b0, req_ready_o, rsp_valid_o}, 32'h2);

    // R2 R3 register map
    cfg_rd(6'd0,  32'h5A31_1F2C, "R2 id dword");
    cfg_rd(6'd1,  32'h0010_0000, "R2 status/command");
    cfg_rd(6'd5,  32'h0000_0040, "R2 cap pointer");
    cfg_rd(6'd16, 32'h0A03_0001, "R3 cap id/next/pmc");
    cfg_rd(6'd17, 32'h2800_0000, "R1 control reset");
    drain();

    // R4 read-only and unused
    cfg_wr(6'd0,  4'hF, 32'hFFFF_FFFF);
    cfg_wr(6'd16, 4'hF, 32'hFFFF_FFFF);
    cfg_wr(6'd3,  4'hF, 32'hFFFF_FFFF);
    cfg_wr(6'd5,  4'hF, 32'hFFFF_FFFF);
    cfg_rd(6'd0,  32'h5A31_1F2C, "R4 id unchanged");
    cfg_rd(6'd16, 32'h0A03_0001, "R4 pmc unchanged");
    cfg_rd(6'd3,  32'h0000_0000, "R4 unused");
    cfg_rd(6'd5,  32'h0000_0040, "R4 pointer unchanged");
    drain();

    // R8 command enables
    cfg_wr(6'd1, 4'h1, 32'h0000_0003);
    @(negedge clk);
    check("R8 enables in D0", {30'b0, io_en_o, mem_en_o}, 32'h3);
    cfg_wr(6'd1, 4'hE, 32'h0000_0000);
    cfg_rd(6'd1, 32'h0010_0003, "R8 command be0 off ignored");
    drain();

    // R5 state selection
    cfg_wr(6'd17, 4'h1, 32'h0000_0002);
    @(negedge clk);
    check("R5 D2 rejected", 32'(pstate_o), 32'h0);
    cfg_wr(6'd17, 4'h1, 32'h0000_0001);
    @(negedge clk);
    check("R5 D1 accepted", 32'(pstate_o), 32'h1);
    check("R8 enables off in D1", {30'b0, io_en_o, mem_en_o}, 32'h0);
    cfg_rd(6'd17, 32'h1400_0001, "R9 data in D1");
    drain();
    cfg_wr(6'd17, 4'h1, 32'h0000_0003);
    @(negedge clk);
    check("R5 D3 accepted", 32'(pstate_o), 32'h3);
    cfg_rd(6'd17, 32'h0500_0003, "R9 data in D3 (R8 cfg honoured)");
    cfg_rd(6'd1,  32'h0010_0003, "R8 command kept in D3");
    drain();
    cfg_wr(6'd17, 4'hE, 32'h0000_0000);
    @(negedge clk);
    check("R5 be0 off ignored", 32'(pstate_o), 32'h3);
    cfg_wr(6'd17, 4'h1, 32'h0000_0000);
    @(negedge clk);
    check("R5 back to D0", 32'(pstate_o), 32'h0);
    check("R8 enables restored", {30'b0, io_en_o, mem_en_o}, 32'h3);

    // R6 R7 wake path
    pme_event_i = 1'b1;
    @(negedge clk);
    pme_event_i = 1'b0;
    check("R7 wake masked", 32'(wake_o), 32'h0);
    cfg_rd(6'd17, 32'h2800_8000, "R6 status set");
    drain();
    cfg_wr(6'd17, 4'h2, 32'h0000_0100);
    @(negedge clk);
    check("R7 wake enabled", 32'(wake_o), 32'h1);
    cfg_wr(6'd17, 4'h2, 32'h0000_8100);
    @(negedge clk);
    check("R6 write-one clear", 32'(wake_o), 32'h0);
    pme_event_i = 1'b1;
    @(negedge clk);
    pme_event_i = 1'b0;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_index_i = 6'd17;
    req_be_i = 4'h2; req_wdata_i = 32'h0000_8100; pme_event_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0; pme_event_i = 1'b0;
    @(negedge clk);
    check("R6 event beats clear", 32'(wake_o), 32'h1);

    // R10 stalled response
    hold_rsp = 1'b1;
    repeat (2) @(negedge clk);
    cfg_rd(6'd5, 32'h0000_0040, "R10 stalled read");
    repeat (3) @(negedge clk);
    check("R10 held valid/not ready", {30'b0, rsp_valid_o, req_ready_o}, 32'h2);
    check("R10 held data", rsp_rdata_o, 32'h0000_0040);
    hold_rsp = 1'b0;
    drain();
    cfg_wr(6'd3, 4'hF, 32'h1);
    repeat (3) @(negedge clk);
    check("R10 write gives no response", 32'(rsp_valid_o), 32'h0);

    finish_run();
  end
endmodule